// File: doc/BRIEF.md
# Phased SPI Master Controller

This block is a single-host SPI master that runs one transaction at a time. A transaction is built from up to four phases that always run in the same order: a command phase, an address phase, a write phase and a read phase. Each phase has its own bit count, and a count of zero skips that phase. In full-duplex mode the write and read phases merge into a single data phase. This phase shifts out the transmit word and samples MISO on the same clock edges. One of three slaves is chosen per transaction. Its chip select stays asserted from before the first SCLK edge until after the last one.

A transaction is requested through a valid/ready handshake. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and all request fields are latched on that edge. While a transaction runs, `req_ready` is low and the controller drops any request it is offered; the requester keeps it pending. The response side has no back-pressure. `rsp_valid` pulses for exactly one cycle, and the receive word on `rsp_data` stays unchanged until the next request is accepted.

The serial clock follows SPI mode 0: idle low, MISO sampled on the rising edge, MOSI changed on the falling edge. Its half period is a whole number of system clock cycles, so the SCLK period is always an even number of system clocks.

Top module: `spi_phase_master`

## Requirements
- R1: The command phase comes first. It sends `min(req_cmd_len,16)` bits, MSB first (bit len-1 down to bit 0 of `req_cmd`), and a length of 0 skips it.
- R2: The address phase follows the command phase. It sends `min(req_addr_len,64)` bits, MSB first (bit len-1 down to bit 0 of `req_addr`), and a length of 0 skips it.
- R3: In half-duplex mode (`req_full_duplex`=0), the write phase sends `min(req_tx_len,32)` bits of `req_tx_data`. The read phase then samples `min(req_rx_len,32)` bits with MOSI held low. A zero length skips the corresponding phase.
- R4: In full-duplex mode, one data phase of `min(req_tx_len,32)` bits drives MOSI and samples MISO on the same edges. `req_rx_len` has no effect, and the number of received bits equals the number of sent bits.
- R5: `req_tx_lsb`=1 sends the data word bit 0 first; 0 sends bit len-1 first. `req_rx_lsb`=1 stores the k-th received bit at position k; 0 stores it at position len-1-k. The received word is right-aligned, and its unused upper bits read 0.
- R6: `req_cs_sel` values 0 to 2 assert only `cs_o[sel]`; value 3 asserts no line. `req_cs_high`=1 makes the active level high, otherwise low. When idle, all lines sit at the inactive level of the most recent request (high after reset).
- R7: SCLK is low when idle. Each half period lasts `req_half_div` system clocks, and a value of 0 counts as 1. For N total bits, the chip select is active for exactly half_div·(2N+1) cycles, and exactly N rising SCLK edges occur.
- R8: `req_ready` is high exactly when `busy` is low. A request offered while busy is ignored and does not alter the running transaction.
- R9: `rsp_valid` is a one-cycle pulse in the last busy cycle, carrying the received word. `busy` is low on the next cycle. Busy lasts half_div·(2N+1)+1 cycles in total.
- R10: After reset, `busy`, `rsp_valid`, `sclk` and `rsp_data` are 0, `req_ready` is 1, and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_cs_sel | input | 2 | Slave index, 3 selects none |
| req_cs_high | input | 1 | Chip select active-high when 1 |
| req_full_duplex | input | 1 | Merge write and read phases |
| req_tx_lsb | input | 1 | Send data LSB first |
| req_rx_lsb | input | 1 | Store received data LSB first |
| req_half_div | input | 8 | SCLK half period in system clocks |
| req_cmd_len | input | 5 | Command bit count |
| req_cmd | input | 16 | Command value, right-aligned |
| req_addr_len | input | 7 | Address bit count |
| req_addr | input | 64 | Address value, right-aligned |
| req_tx_len | input | 6 | Write / full-duplex bit count |
| req_tx_data | input | 32 | Transmit word, right-aligned |
| req_rx_len | input | 6 | Half-duplex read bit count |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 3 | Per-slave chip selects |

## Verification
The assertions watch the handshake and the framing on every cycle. Busy persists until the completion pulse, and the pulse is one cycle wide. At most one chip select is active, and every line sits at the inactive level when idle. The select lines stay constant inside a transaction, SCLK rests low between transactions, and MOSI holds steady while SCLK is high.

The content of a transaction can only be shown by the bench's sweeps. These scenarios cover:
- the bit sequence across the skippable phases and the phase ordering;
- the clamping of oversized lengths;
- both bit orders;
- full- versus half-duplex receive alignment;
- the exact duration of chip select and busy;
- requests that arrive while busy and must have no effect.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_END  = 2'd3
  } state_e;

  // Numeric order of the phases is the order they run in.
  typedef enum logic [2:0] {
    PH_CMD  = 3'd0,
    PH_ADDR = 3'd1,
    PH_WR   = 3'd2,
    PH_RD   = 3'd3,
    PH_END  = 3'd4
  } phase_e;

  localparam int NUM_PH = 4;

  // First non-empty phase at or after 'from'; PH_END when none remains.
  function automatic phase_e pick_phase(input logic [NUM_PH-1:0] nz, input logic [2:0] from);
    phase_e r;
    r = PH_END;
    for (int i = NUM_PH - 1; i >= 0; i--) begin
      if (nz[i] && (3'(i) >= from)) r = phase_e'(3'(i));
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_pm_clkdiv.sv
module spi_pm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/spi_pm_txmux.sv
module spi_pm_txmux
  import spi_pm_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7
) (
  input  phase_e            phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  cmd_len,
  input  logic [IDX_W-1:0]  addr_len,
  input  logic [IDX_W-1:0]  tx_len,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] tx,
  input  logic              tx_lsb,
  output logic              bit_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] cpos, apos, dpos;

  assign cpos = cmd_len - idx - ONE;
  assign apos = addr_len - idx - ONE;
  assign dpos = tx_lsb ? idx : (tx_len - idx - ONE);

  always_comb begin
    unique case (phase)
      PH_CMD:  bit_o = |(cmd  & (CMD_W'(1)  << cpos));
      PH_ADDR: bit_o = |(addr & (ADDR_W'(1) << apos));
      PH_WR:   bit_o = |(tx   & (DATA_W'(1) << dpos));
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_pm_rxasm.sv
module spi_pm_rxasm #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              bit_in,
  input  logic              lsb,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q, mask;

  assign mask   = DATA_W'(1) << idx;
  assign data_o = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (clear)  data_q <= '0;
    else if (sample) begin
      if (lsb) data_q <= bit_in ? (data_q | mask) : (data_q & ~mask);
      else     data_q <= {data_q[DATA_W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
  import spi_pm_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 8,
  localparam int CMD_LW  = $clog2(CMD_W + 1),
  localparam int ADDR_LW = $clog2(ADDR_W + 1),
  localparam int DATA_LW = $clog2(DATA_W + 1),
  localparam int SEL_W   = $clog2(NUM_CS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SEL_W-1:0]   req_cs_sel,
  input  logic               req_cs_high,
  input  logic               req_full_duplex,
  input  logic               req_tx_lsb,
  input  logic               req_rx_lsb,
  input  logic [DIV_W-1:0]   req_half_div,
  input  logic [CMD_LW-1:0]  req_cmd_len,
  input  logic [CMD_W-1:0]   req_cmd,
  input  logic [ADDR_LW-1:0] req_addr_len,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_LW-1:0] req_tx_len,
  input  logic [DATA_W-1:0]  req_tx_data,
  input  logic [DATA_LW-1:0] req_rx_len,
  output logic               busy,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_CS-1:0]  cs_o
);
  localparam int MAX_LEN = (CMD_W > ADDR_W) ? ((CMD_W > DATA_W) ? CMD_W : DATA_W)
                                            : ((ADDR_W > DATA_W) ? ADDR_W : DATA_W);
  localparam int IDX_W = $clog2(MAX_LEN + 1);
  localparam logic [IDX_W-1:0] IONE = IDX_W'(1);

  state_e st_q;
  phase_e phase_q;
  logic [IDX_W-1:0] idx_q, cur_len;
  logic [IDX_W-1:0] cmd_len_q, addr_len_q, tx_len_q, rx_len_q;
  logic [IDX_W-1:0] cmd_len_d, addr_len_d, tx_len_d, rx_len_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] tx_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DIV_W-1:0]  div_q;
  logic fd_q, tx_lsb_q, rx_lsb_q, pol_q;
  logic [NUM_PH-1:0] nz_q, nz_d;
  logic accept, cs_on, tick, last_bit, sample_en, tx_bit;
  phase_e next_ph;

  // Length clamping at the request edge
  assign cmd_len_d  = (req_cmd_len  > CMD_LW'(CMD_W))   ? IDX_W'(CMD_W)  : IDX_W'(req_cmd_len);
  assign addr_len_d = (req_addr_len > ADDR_LW'(ADDR_W)) ? IDX_W'(ADDR_W) : IDX_W'(req_addr_len);
  assign tx_len_d   = (req_tx_len   > DATA_LW'(DATA_W)) ? IDX_W'(DATA_W) : IDX_W'(req_tx_len);
  assign rx_len_d   = (req_rx_len   > DATA_LW'(DATA_W)) ? IDX_W'(DATA_W) : IDX_W'(req_rx_len);

  assign nz_d = {(!req_full_duplex && rx_len_d != '0), tx_len_d != '0,
                 addr_len_d != '0, cmd_len_d != '0};
  assign nz_q = {(!fd_q && rx_len_q != '0), tx_len_q != '0,
                 addr_len_q != '0, cmd_len_q != '0};

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = (st_q != ST_IDLE);
  assign rsp_valid = (st_q == ST_END);
  assign cs_on     = (st_q == ST_LO) || (st_q == ST_HI);
  assign sclk      = (st_q == ST_HI);
  assign mosi      = cs_on && tx_bit;

  always_comb begin
    unique case (phase_q)
      PH_CMD:  cur_len = cmd_len_q;
      PH_ADDR: cur_len = addr_len_q;
      PH_WR:   cur_len = tx_len_q;
      PH_RD:   cur_len = rx_len_q;
      default: cur_len = '0;
    endcase
  end

  assign last_bit  = (idx_q == cur_len - IONE);
  assign next_ph   = pick_phase(nz_q, 3'(phase_q) + 3'd1);
  assign sample_en = (st_q == ST_LO) && tick &&
                     ((phase_q == PH_RD) || ((phase_q == PH_WR) && fd_q));

  // Request latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_len_q <= '0; addr_len_q <= '0; tx_len_q <= '0; rx_len_q <= '0;
      cmd_q <= '0; addr_q <= '0; tx_q <= '0;
      sel_q <= '0; div_q <= DIV_W'(1);
      fd_q <= 1'b0; tx_lsb_q <= 1'b0; rx_lsb_q <= 1'b0; pol_q <= 1'b0;
    end else if (accept) begin
      cmd_len_q  <= cmd_len_d;
      addr_len_q <= addr_len_d;
      tx_len_q   <= tx_len_d;
      rx_len_q   <= rx_len_d;
      cmd_q      <= req_cmd;
      addr_q     <= req_addr;
      tx_q       <= req_tx_data;
      sel_q      <= req_cs_sel;
      div_q      <= (req_half_div == '0) ? DIV_W'(1) : req_half_div;
      fd_q       <= req_full_duplex;
      tx_lsb_q   <= req_tx_lsb;
      rx_lsb_q   <= req_rx_lsb;
      pol_q      <= req_cs_high;
    end
  end

  // Sequencer: LO/HI half periods, phase walk, completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= PH_END;
      idx_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_LO;
          phase_q <= pick_phase(nz_d, 3'd0);
          idx_q   <= '0;
        end
        ST_LO: if (tick) st_q <= (phase_q == PH_END) ? ST_END : ST_HI;
        ST_HI: if (tick) begin
          st_q <= ST_LO;
          if (last_bit) begin
            phase_q <= next_ph;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + IONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  spi_pm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(cs_on), .half_div(div_q), .tick(tick)
  );

  spi_pm_txmux #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_txmux (
    .phase(phase_q), .idx(idx_q), .cmd_len(cmd_len_q), .addr_len(addr_len_q),
    .tx_len(tx_len_q), .cmd(cmd_q), .addr(addr_q), .tx(tx_q), .tx_lsb(tx_lsb_q),
    .bit_o(tx_bit)
  );

  spi_pm_rxasm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(sample_en), .bit_in(miso),
    .lsb(rx_lsb_q), .idx(idx_q), .data_o(rsp_data)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_o[g] = (cs_on && (sel_q == SEL_W'(g))) ? pol_q : ~pol_q;
  end
endmodule

// File: rtl/spi_pm_chk.sv
module spi_pm_chk #(
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_o,
  input logic              cs_pol
);
  // R8
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !rsp_valid));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ {NUM_CS{~cs_pol}}));

  // R6
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_o == {NUM_CS{~cs_pol}}));

  // R6
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !rsp_valid) |-> $stable(cs_o));

  // R7
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

bind spi_phase_master spi_pm_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .rsp_valid(rsp_valid), .sclk(sclk), .mosi(mosi),
  .cs_o(cs_o), .cs_pol(pol_q)
);

// File: tb/tb_spi_phase_master.sv
module tb_spi_phase_master;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 3;

  logic clk, rst_n, req_valid, req_ready, req_cs_high, req_full_duplex;
  logic req_tx_lsb, req_rx_lsb, busy, rsp_valid, sclk, mosi, miso;
  logic [1:0]  req_cs_sel;
  logic [7:0]  req_half_div;
  logic [4:0]  req_cmd_len;
  logic [15:0] req_cmd;
  logic [6:0]  req_addr_len;
  logic [63:0] req_addr;
  logic [5:0]  req_tx_len, req_rx_len;
  logic [31:0] req_tx_data, rsp_data;
  logic [NCS-1:0] cs_o;

  spi_phase_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs_sel(req_cs_sel), .req_cs_high(req_cs_high), .req_full_duplex(req_full_duplex),
    .req_tx_lsb(req_tx_lsb), .req_rx_lsb(req_rx_lsb), .req_half_div(req_half_div),
    .req_cmd_len(req_cmd_len), .req_cmd(req_cmd), .req_addr_len(req_addr_len),
    .req_addr(req_addr), .req_tx_len(req_tx_len), .req_tx_data(req_tx_data),
    .req_rx_len(req_rx_len), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int n_chk = 0, n_bad = 0;

  // Slave model: MISO streams slave_pat bit by rising-edge count.
  logic [63:0] slave_pat = '0;
  int rise_cnt = 0, rise_base = 0;
  logic got_bits [0:255];
  assign miso = slave_pat[6'(rise_cnt - rise_base)];

  always @(posedge sclk) begin : cap
    int o;
    o = rise_cnt - rise_base;
    if (o >= 0 && o < 256) got_bits[o] = mosi;
    rise_cnt = rise_cnt + 1;
  end

  // Chip-select monitor, sampled mid-cycle
  int exp_sel = 0;
  logic exp_pol = 1'b0;
  int sel_act = 0, other_act = 0, busy_cyc = 0;
  always @(negedge clk) begin
    if (busy) begin
      busy_cyc++;
      for (int i = 0; i < NCS; i++) begin
        if (cs_o[i] == exp_pol) begin
          if (i == exp_sel) sel_act++;
          else other_act++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int clampi(input int v, input int m);
    return (v > m) ? m : v;
  endfunction

  task automatic run_txn(input int cl, input int al, input int tl, input int rl,
                         input bit fd, input bit tlsb, input bit rlsb, input bit csh,
                         input int sel, input int div, input logic [15:0] cmd,
                         input logic [63:0] addr, input logic [31:0] tx,
                         input logic [63:0] pat, input bit poke);
    int ecl, eal, etl, erl, nrx, n, ediv, rbase, cyc, sa0, oa0, bc0, mism;
    logic exp_b [0:255];
    logic [31:0] exp_rx, got_rx;
    string tag;
    ecl = clampi(cl, 16); eal = clampi(al, 64); etl = clampi(tl, 32);
    erl = fd ? 0 : clampi(rl, 32);
    nrx = fd ? etl : erl;
    ediv = (div == 0) ? 1 : div;
    n = 0;
    for (int i = 0; i < ecl; i++) begin exp_b[n] = cmd[ecl-1-i]; n++; end
    for (int i = 0; i < eal; i++) begin exp_b[n] = addr[eal-1-i]; n++; end
    for (int i = 0; i < etl; i++) begin exp_b[n] = tlsb ? tx[i] : tx[etl-1-i]; n++; end
    for (int i = 0; i < erl; i++) begin exp_b[n] = 1'b0; n++; end
    rbase = ecl + eal + (fd ? 0 : etl);
    exp_rx = '0;
    for (int j = 0; j < nrx; j++) exp_rx[rlsb ? j : nrx-1-j] = pat[(rbase + j) % 64];

    slave_pat = pat; rise_base = rise_cnt;
    exp_sel = sel; exp_pol = csh;
    sa0 = sel_act; oa0 = other_act; bc0 = busy_cyc;

    req_cmd_len = 5'(cl); req_addr_len = 7'(al); req_tx_len = 6'(tl); req_rx_len = 6'(rl);
    req_full_duplex = fd; req_tx_lsb = tlsb; req_rx_lsb = rlsb; req_cs_high = csh;
    req_cs_sel = 2'(sel); req_half_div = 8'(div);
    req_cmd = cmd; req_addr = addr; req_tx_data = tx;
    chk(req_ready === 1'b1, "R8 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      for (int p = 0; p < 4; p++) begin
        req_valid = 1'b1; req_cmd_len = 5'd3; req_cs_sel = 2'(sel + 1);
        req_tx_data = ~tx; req_cs_high = ~csh; req_full_duplex = ~fd;
        chk(req_ready === 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!rsp_valid && cyc < 6000) begin @(negedge clk); cyc++; end
    got_rx = rsp_data;
    chk(rsp_valid === 1'b1, "R9 completion pulse seen", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    chk(!busy && !rsp_valid, "R9 busy and pulse drop after done",
        64'({busy, rsp_valid}), 64'd0);
    chk(cs_o === {NCS{~csh}}, "R6 idle lines at inactive level", 64'(cs_o), 64'({NCS{~csh}}));
    chk(rise_cnt - rise_base == n, "R7 rising edge count", 64'(rise_cnt - rise_base), 64'(n));
    mism = -1;
    for (int i = n - 1; i >= 0; i--) if (got_bits[i] !== exp_b[i]) mism = i;
    if (mism < 0) tag = "R1/R2/R3 bit stream";
    else if (mism < ecl) tag = "R1 command bits";
    else if (mism < ecl + eal) tag = "R2 address bits";
    else if (fd) tag = "R4/R5 full-duplex out bits";
    else tag = "R3/R5 write/read out bits";
    chk(mism < 0, tag, 64'(mism), 64'hFFFF_FFFF_FFFF_FFFF);
    chk(got_rx === exp_rx, fd ? "R4/R5 received word" : "R3/R5 received word",
        64'(got_rx), 64'(exp_rx));
    chk(sel_act - sa0 == ((sel < NCS) ? ediv * (2*n + 1) : 0), "R7 chip-select active cycles",
        64'(sel_act - sa0), 64'((sel < NCS) ? ediv * (2*n + 1) : 0));
    chk(other_act == oa0, "R6 unselected lines stay inactive", 64'(other_act - oa0), 64'd0);
    chk(busy_cyc - bc0 == ediv * (2*n + 1) + 1, "R9 busy duration",
        64'(busy_cyc - bc0), 64'(ediv * (2*n + 1) + 1));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired got 0 exp 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int k;
    int cls[3] = '{0, 1, 16};
    int als[3] = '{0, 5, 64};
    int tls[3] = '{0, 1, 32};
    int rls[3] = '{0, 9, 32};
    rst_n = 1'b0; req_valid = 1'b0; req_cs_sel = '0; req_cs_high = 1'b0;
    req_full_duplex = 1'b0; req_tx_lsb = 1'b0; req_rx_lsb = 1'b0; req_half_div = 8'd1;
    req_cmd_len = '0; req_cmd = '0; req_addr_len = '0; req_addr = '0;
    req_tx_len = '0; req_tx_data = '0; req_rx_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(!busy && !rsp_valid && !sclk && req_ready, "R10 control outputs after reset",
        64'({busy, rsp_valid, sclk, req_ready}), 64'b0001);
    chk(cs_o === 3'b111 && rsp_data === '0, "R10 selects and data after reset",
        64'({cs_o, rsp_data}), 64'({3'b111, 32'd0}));

    // Empty transaction: chip select for one half period only (R7)
    run_txn(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 16'h0, 64'h0, 32'h0, 64'h0, 0);
    // Oversized lengths clamp, divider 0 acts as 1 (R1 R2 R3 R7)
    run_txn(20, 70, 40, 50, 0, 0, 1, 1, 2, 0, 16'hC3A5, 64'h0123_4567_89AB_CDEF,
            32'hF00D_BEEF, 64'hA5A5_3C3C_0FF0_9696, 0);
    // Requests while busy are ignored (R8)
    run_txn(8, 8, 16, 0, 1, 1, 0, 0, 0, 2, 16'h005A, 64'h77, 32'h1234_5678,
            64'h5555_AAAA_3333_CCCC, 1);
    // Full duplex ignores rx length (R4)
    run_txn(0, 0, 12, 31, 1, 0, 1, 1, 3, 1, 16'h0, 64'h0, 32'h0000_0ABC,
            64'hDEAD_BEEF_CAFE_F00D, 0);

    k = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++)
            for (int f = 0; f < 2; f++) begin
              run_txn(cls[a], als[b], tls[c], rls[d], f[0], k[1], (k / 3) % 2 == 1,
                      (k / 5) % 2 == 1, k % 4, 1 + (k % 3),
                      16'(k * 40503 + 1234),
                      {32'(k * 32'h9E37_79B1), 32'(k * 40503) ^ 32'hDEAD_BEEF},
                      32'(k * 32'h85EB_CA77 + 7),
                      {32'(k * 32'hC2B2_AE3D + 11), 32'(k * 32'h27D4_EB2F) ^ 32'h5A5A_0F0F},
                      0);
              k++;
            end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule